// File: doc/BRIEF.md
# UART Register Front End

This block connects a processor's word-addressed register bus to two byte queues, one for outgoing and one for incoming serial data. Software writes bytes into the outgoing queue and reads bytes from the incoming queue through a seven-register window. The queue status sits in the top bit of the data word. Outside the window the block answers with one of two error codes. Interrupt enable, interrupt pending and the baud divisor are placeholders that return fixed values.

On the line side, a serializer takes bytes from the outgoing queue through a valid/ready port, and a deserializer delivers bytes into the incoming queue through a second valid/ready port. Each port moves data only while its enable bit in the matching control register is set. Serialization, baud timing and interrupts are handled elsewhere.

The bus side is driven by a two-state machine. BUS_IDLE moves to BUS_RESP when a request arrives. BUS_RESP stays in BUS_RESP on a further request, which allows back-to-back requests, and returns to BUS_IDLE when no request arrives. The response is valid only in BUS_RESP.

Top module: `uart_reg_frontend`

## Requirements
- R1: After reset both enable bits are 0, rsp_valid is 0, txs_valid is 0 and rxd_ready is 0.
- R2: Every cycle with req_valid high is answered by rsp_valid high in the next cycle. No response appears without a request.
- R3: A write to offset 0x00 pushes wdata[7:0] into the outgoing queue. Bytes leave on txs_data in the order they were written, one per cycle in which txs_valid and txs_ready are both high.
- R4: A read of offset 0x00 returns 0x8000_0000 when the outgoing queue holds FIFO_DEPTH bytes and 0 otherwise. A write to offset 0x00 while the queue is full drops the byte and leaves the queue unchanged.
- R5: A read of offset 0x04 removes the oldest incoming byte and returns it zero-extended. When the incoming queue is empty, the read returns 0x8000_0000 and removes nothing.
- R6: Offsets 0x08 (outgoing enable) and 0x0C (incoming enable) store wdata[0] on a write. A read returns that bit in bit 0, with all other bits 0.
- R7: txs_valid is high only while the outgoing enable is set and the queue is non-empty. rxd_ready is high only while the incoming enable is set and the incoming queue is not full.
- R8: Reads of offsets 0x10 and 0x14 return 0, and a read of 0x18 returns 1. Writes to 0x04, 0x10, 0x14 and 0x18 succeed with no effect.
- R9: An offset below 0x1C that names no register gets rsp_err 1 (misaligned). The access has no effect and returns rdata 0.
- R10: An offset at or above 0x1C gets rsp_err 2 (access fault). The access has no effect and returns rdata 0.
- R11: Accesses to mapped offsets get rsp_err 0. Write responses carry rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 2 | 0 ok, 1 misaligned, 2 access fault |
| rsp_rdata | output | 32 | Read data |
| txs_valid | output | 1 | Outgoing byte available to the serializer |
| txs_data | output | 8 | Oldest outgoing byte |
| txs_ready | input | 1 | Serializer takes the byte |
| rxd_valid | input | 1 | Deserializer offers a byte |
| rxd_data | input | 8 | Incoming byte |
| rxd_ready | output | 1 | Incoming queue accepts the byte |

## Verification
The bench fills the outgoing queue to exactly FIFO_DEPTH bytes, then writes one more. If the design wrapped or overwrote on that write, the drained stream would show a stray 0xEE or lose its first byte. An incoming byte of 0x80 is read back to catch a design that confuses data bit 7 with the empty flag. Reads of an empty incoming queue are repeated to catch a pointer that moves on an empty pop. Offsets 0x01, 0x0E, 0x1B, 0x1C and 0x100 separate the two error codes at the window edge. The bench confirms that rejected writes and writes to the receive data register never put a byte into either queue.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    typedef enum logic [1:0] {
        ERR_OK       = 2'd0,
        ERR_MISALIGN = 2'd1,
        ERR_FAULT    = 2'd2
    } bus_err_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TXD,
        SEL_RXD,
        SEL_TXC,
        SEL_RXC,
        SEL_IEN,
        SEL_IPEND,
        SEL_DIV
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;

    localparam int OFF_TXD   = 'h00;
    localparam int OFF_RXD   = 'h04;
    localparam int OFF_TXC   = 'h08;
    localparam int OFF_RXC   = 'h0C;
    localparam int OFF_IEN   = 'h10;
    localparam int OFF_IPEND = 'h14;
    localparam int OFF_DIV   = 'h18;
    localparam int WIN_END   = 'h1C;

    localparam logic [31:0] STATUS_FLAG = 32'h8000_0000;
    localparam logic [31:0] DIV_VALUE   = 32'h0000_0001;

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output bus_err_e          err
);
    localparam logic [ADDR_W-1:0] A_TXD   = ADDR_W'(OFF_TXD);
    localparam logic [ADDR_W-1:0] A_RXD   = ADDR_W'(OFF_RXD);
    localparam logic [ADDR_W-1:0] A_TXC   = ADDR_W'(OFF_TXC);
    localparam logic [ADDR_W-1:0] A_RXC   = ADDR_W'(OFF_RXC);
    localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFF_IEN);
    localparam logic [ADDR_W-1:0] A_IPEND = ADDR_W'(OFF_IPEND);
    localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(OFF_DIV);
    localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(WIN_END);

    always_comb begin
        sel = SEL_NONE;
        unique case (addr)
            A_TXD:   sel = SEL_TXD;
            A_RXD:   sel = SEL_RXD;
            A_TXC:   sel = SEL_TXC;
            A_RXC:   sel = SEL_RXC;
            A_IEN:   sel = SEL_IEN;
            A_IPEND: sel = SEL_IPEND;
            A_DIV:   sel = SEL_DIV;
            default: sel = SEL_NONE;
        endcase
        if (sel != SEL_NONE) begin
            err = ERR_OK;
        end else if (addr < A_END) begin
            err = ERR_MISALIGN;
        end else begin
            err = ERR_FAULT;
        end
    end
endmodule

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
    parameter int DEPTH = 2048,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CNT_MAX);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_reg_frontend.sv
module uart_reg_frontend
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int FIFO_DEPTH = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              txs_valid,
    output logic [7:0]        txs_data,
    input  logic              txs_ready,
    input  logic              rxd_valid,
    input  logic [7:0]        rxd_data,
    output logic              rxd_ready
);
    bus_state_e state, state_nx;
    reg_sel_e   sel;
    bus_err_e   dec_err;
    logic       tx_en, rx_en;
    logic       tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0] rx_head;
    logic       acc_ok, tx_push, tx_pop, rx_push, rx_pop;
    logic [31:0] rd_word;

    uart_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .sel  (sel),
        .err  (dec_err)
    );

    assign acc_ok    = req_valid && (dec_err == ERR_OK);
    assign tx_push   = acc_ok && req_write && (sel == SEL_TXD);
    assign rx_pop    = acc_ok && !req_write && (sel == SEL_RXD) && !rx_empty;
    assign txs_valid = tx_en && !tx_empty;
    assign tx_pop    = txs_valid && txs_ready;
    assign rxd_ready = rx_en && !rx_full;
    assign rx_push   = rxd_valid && rxd_ready;

    uart_rf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .din   (req_wdata[7:0]),
        .pop   (tx_pop),
        .dout  (txs_data),
        .full  (tx_full),
        .empty (tx_empty)
    );

    uart_rf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .din   (rxd_data),
        .pop   (rx_pop),
        .dout  (rx_head),
        .full  (rx_full),
        .empty (rx_empty)
    );

    // Control enables
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
        end else if (acc_ok && req_write) begin
            if (sel == SEL_TXC) tx_en <= req_wdata[0];
            if (sel == SEL_RXC) rx_en <= req_wdata[0];
        end
    end

    // Read data selection
    always_comb begin
        rd_word = '0;
        unique case (sel)
            SEL_TXD:   rd_word = tx_full ? STATUS_FLAG : 32'd0;
            SEL_RXD:   rd_word = rx_empty ? STATUS_FLAG : {24'd0, rx_head};
            SEL_TXC:   rd_word = {31'd0, tx_en};
            SEL_RXC:   rd_word = {31'd0, rx_en};
            SEL_DIV:   rd_word = DIV_VALUE;
            SEL_IEN,
            SEL_IPEND,
            SEL_NONE:  rd_word = 32'd0;
            default:   rd_word = 32'd0;
        endcase
    end

    // Bus state machine: next state
    always_comb begin
        state_nx = state;
        unique case (state)
            BUS_IDLE: state_nx = req_valid ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_nx = req_valid ? BUS_RESP : BUS_IDLE;
            default:  state_nx = BUS_IDLE;
        endcase
    end

    // Bus state machine: state register
    always_ff @(posedge clk) begin
        if (rst) state <= BUS_IDLE;
        else     state <= state_nx;
    end

    // Bus state machine: registered response outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_err   <= ERR_OK;
            rsp_rdata <= '0;
        end else if (req_valid) begin
            rsp_err   <= dec_err;
            rsp_rdata <= (acc_ok && !req_write) ? rd_word : 32'd0;
        end
    end

    assign rsp_valid = (state == BUS_RESP);
endmodule

// File: rtl/uart_rf_checker.sv
module uart_rf_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic        rsp_valid,
    input logic [1:0]  rsp_err,
    input logic [31:0] rsp_rdata,
    input logic        txs_valid,
    input logic        rxd_ready,
    input logic        tx_en,
    input logic        rx_en
);
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r7_drain_needs_enable: assert property (@(posedge clk) disable iff (rst)
        txs_valid |-> tx_en);

    a_r7_fill_needs_enable: assert property (@(posedge clk) disable iff (rst)
        rxd_ready |-> rx_en);

    // R9 / R10: error responses carry no data and use a defined code
    a_r10_err_code_legal: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_err != 2'd3);

    a_r9_err_no_data: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err != 2'd0) |-> rsp_rdata == 32'd0);

    a_r5_flag_alone: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_rdata[31]) |-> rsp_rdata[30:0] == 31'd0);

    a_r6_enable_write_only: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> ($stable(tx_en) && $stable(rx_en)));
endmodule

bind uart_reg_frontend uart_rf_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .txs_valid (txs_valid),
    .rxd_ready (rxd_ready),
    .tx_en     (tx_en),
    .rx_en     (rx_en)
);

// File: tb/sim_uart_reg_frontend.sv
`timescale 1ns/1ps
module sim_uart_reg_frontend;
    localparam int ADDR_W = 12;
    localparam int DEPTH  = 2048;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_err;
    logic [31:0]       rsp_rdata;
    logic              txs_valid;
    logic [7:0]        txs_data;
    logic              txs_ready = 1'b0;
    logic              rxd_valid = 1'b0;
    logic [7:0]        rxd_data = '0;
    logic              rxd_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    uart_reg_frontend #(.ADDR_W(ADDR_W), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .txs_valid(txs_valid), .txs_data(txs_data),
        .txs_ready(txs_ready), .rxd_valid(rxd_valid), .rxd_data(rxd_data),
        .rxd_ready(rxd_ready)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [1:0]  err;
        logic [31:0] rdata;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h008, 32'h0,        2'd0, 32'h0},        // R1 tx enable resets 0
        '{1'b1, 12'h008, 32'hFFFF_FFFF, 2'd0, 32'h0},       // R6 R11
        '{1'b0, 12'h008, 32'h0,        2'd0, 32'h1},        // R6
        '{1'b1, 12'h008, 32'h2,        2'd0, 32'h0},        // R6 only bit 0
        '{1'b0, 12'h008, 32'h0,        2'd0, 32'h0},        // R6
        '{1'b1, 12'h00C, 32'h1,        2'd0, 32'h0},        // R6
        '{1'b0, 12'h00C, 32'h0,        2'd0, 32'h1},        // R6
        '{1'b1, 12'h00C, 32'h0,        2'd0, 32'h0},        // R6
        '{1'b0, 12'h00C, 32'h0,        2'd0, 32'h0},        // R6
        '{1'b0, 12'h010, 32'h0,        2'd0, 32'h0},        // R8
        '{1'b0, 12'h014, 32'h0,        2'd0, 32'h0},        // R8
        '{1'b0, 12'h018, 32'h0,        2'd0, 32'h1},        // R8
        '{1'b1, 12'h018, 32'h55,       2'd0, 32'h0},        // R8
        '{1'b0, 12'h018, 32'h0,        2'd0, 32'h1},        // R8
        '{1'b1, 12'h010, 32'hFFFF_FFFF, 2'd0, 32'h0},       // R8
        '{1'b0, 12'h010, 32'h0,        2'd0, 32'h0},        // R8
        '{1'b1, 12'h014, 32'hFFFF_FFFF, 2'd0, 32'h0},       // R8
        '{1'b0, 12'h014, 32'h0,        2'd0, 32'h0},        // R8
        '{1'b0, 12'h004, 32'h0,        2'd0, 32'h8000_0000}, // R5 empty
        '{1'b1, 12'h004, 32'h12,       2'd0, 32'h0},        // R8
        '{1'b0, 12'h004, 32'h0,        2'd0, 32'h8000_0000}, // R5 still empty
        '{1'b0, 12'h001, 32'h0,        2'd1, 32'h0},        // R9
        '{1'b1, 12'h01B, 32'h77,       2'd1, 32'h0},        // R9
        '{1'b0, 12'h01C, 32'h0,        2'd2, 32'h0},        // R10
        '{1'b0, 12'h100, 32'h0,        2'd2, 32'h0},        // R10
        '{1'b0, 12'h000, 32'h0,        2'd0, 32'h0},        // R4 not full
        '{1'b1, 12'h00E, 32'h1,        2'd1, 32'h0}         // R9
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [1:0] e, output logic [31:0] r);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        e = rsp_err;
        r = rsp_rdata;
    endtask

    task automatic drain(input logic [7:0] exp, input string tag);
        @(negedge clk);
        chk({tag, " txs_valid"}, {31'd0, txs_valid}, 32'd1);
        chk({tag, " txs_data"}, {24'd0, txs_data}, {24'd0, exp});
        txs_ready = 1'b1;
        @(negedge clk);
        txs_ready = 1'b0;
    endtask

    task automatic fill(input logic [7:0] b);
        @(negedge clk);
        rxd_valid = 1'b1; rxd_data = b;
        @(negedge clk);
        rxd_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0]  e;
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 txs_valid", {31'd0, txs_valid}, 32'd0);
        chk("R1 rxd_ready", {31'd0, rxd_ready}, 32'd0);
        @(negedge clk);
        chk("R2 no spurious rsp", {31'd0, rsp_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            bus(VECS[i].wr, VECS[i].addr, VECS[i].wdata, e, r);
            chk($sformatf("R11 vec%0d err", i), {30'd0, e}, {30'd0, VECS[i].err});
            chk($sformatf("R8 vec%0d rdata", i), r, VECS[i].rdata);
        end

        // R3 push while disabled: nothing on drain port
        bus(1'b1, 12'h000, 32'hABCD_12A5, e, r);
        @(negedge clk);
        chk("R7 drain gated off", {31'd0, txs_valid}, 32'd0);
        bus(1'b1, 12'h008, 32'h1, e, r);
        drain(8'hA5, "R3 low byte");
        bus(1'b1, 12'h000, 32'h11, e, r);
        bus(1'b1, 12'h000, 32'h22, e, r);
        bus(1'b1, 12'h000, 32'h33, e, r);
        drain(8'h11, "R3 order0");
        drain(8'h22, "R3 order1");
        drain(8'h33, "R3 order2");
        @(negedge clk);
        chk("R7 empty no valid", {31'd0, txs_valid}, 32'd0);

        // R9/R10/R8: rejected and dummy writes push nothing
        bus(1'b1, 12'h001, 32'h99, e, r);
        bus(1'b1, 12'h01C, 32'h98, e, r);
        bus(1'b1, 12'h004, 32'h97, e, r);
        @(negedge clk);
        chk("R9 R10 no push", {31'd0, txs_valid}, 32'd0);

        // R4 fill to full, overflow dropped
        bus(1'b1, 12'h008, 32'h0, e, r);
        for (int i = 0; i < DEPTH; i++) bus(1'b1, 12'h000, 32'(i), e, r);
        bus(1'b0, 12'h000, 32'h0, e, r);
        chk("R4 full flag", r, 32'h8000_0000);
        bus(1'b1, 12'h000, 32'hEE, e, r);
        bus(1'b1, 12'h008, 32'h1, e, r);
        for (int i = 0; i < DEPTH; i++) drain(8'(i), "R4 drain");
        @(negedge clk);
        chk("R4 overflow dropped", {31'd0, txs_valid}, 32'd0);
        bus(1'b0, 12'h000, 32'h0, e, r);
        chk("R4 not full", r, 32'h0);

        // R5 receive path
        @(negedge clk);
        chk("R7 fill gated off", {31'd0, rxd_ready}, 32'd0);
        fill(8'h5A);
        bus(1'b0, 12'h004, 32'h0, e, r);
        chk("R7 ignored while disabled", r, 32'h8000_0000);
        bus(1'b1, 12'h00C, 32'h1, e, r);
        @(negedge clk);
        chk("R7 fill ready", {31'd0, rxd_ready}, 32'd1);
        fill(8'h80);
        fill(8'h01);
        fill(8'hFF);
        bus(1'b0, 12'h004, 32'h0, e, r);
        chk("R5 byte 0x80", r, 32'h0000_0080);
        bus(1'b0, 12'h004, 32'h0, e, r);
        chk("R5 byte 0x01", r, 32'h0000_0001);
        bus(1'b0, 12'h004, 32'h0, e, r);
        chk("R5 byte 0xFF", r, 32'h0000_00FF);
        bus(1'b0, 12'h004, 32'h0, e, r);
        chk("R5 empty again", r, 32'h8000_0000);
        bus(1'b0, 12'h004, 32'h0, e, r);
        chk("R5 empty no pop", r, 32'h8000_0000);
        fill(8'h42);
        bus(1'b0, 12'h004, 32'h0, e, r);
        chk("R5 after empty reads", r, 32'h0000_0042);

        // R7 incoming full blocks further bytes
        for (int i = 0; i < DEPTH; i++) fill(8'(i + 3));
        @(negedge clk);
        chk("R7 full not ready", {31'd0, rxd_ready}, 32'd0);
        bus(1'b0, 12'h004, 32'h0, e, r);
        chk("R5 oldest of full", r, 32'h0000_0003);
        @(negedge clk);
        chk("R7 ready after pop", {31'd0, rxd_ready}, 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule